// File: doc/BRIEF.md
# Indirect Control-Register Access Window

This block gives a processor core a narrow window through which it reaches a set of control registers that have no address of their own. Each of three privilege levels (machine, supervisor, virtual supervisor) owns one select register and six alias addresses. Software writes an index into its select register. A read or write on an alias then lands on whichever target register is keyed by that level, that select value and that alias position.

The block decodes one control-register access per cycle. The access carries a 12-bit address, a write enable, write data, the current privilege mode and the virtualization bit. Read data and the two trap flags come back in the same cycle. While virtualization is active, supervisor-level select and alias addresses are steered to the virtual-supervisor copies. The target table is a parameter: each entry names a level, a select value, an alias position and a reset value. This lets the window be exercised without the real register files it would front in a full core.

Top module: `csr_ind_window`

## Requirements
- R1: After reset all three select registers read zero and every target holds its parameterised reset value.
- R2: An address is in the window when bits [11:10] are 00, bits [7:4] are 0x5, bits [9:8] are not 00 (11 machine, 01 supervisor, 10 virtual supervisor) and bits [3:0] are 0–3 or 5–7. Low nibble 0 is the select register. Nibbles 1–3 are alias positions 0–2 and nibbles 5–7 are alias positions 3–5. Any other address, or a cycle with req_valid_i low, raises no trap, reads zero and writes nothing.
- R3: A permitted access to a select address reads or writes the full-width select register of its effective level. A write is visible from the next cycle.
- R4: A permitted alias access reads or writes the target whose level, select value and alias position match the effective level, that level's current select value and the alias position. The lowest-numbered matching entry wins.
- R5: When the effective virtualization bit (virt_i set and priv_i not machine, 11) is 1, supervisor select and alias addresses act on the virtual-supervisor select register and targets. In machine mode virt_i has no effect.
- R6: An alias access with no matching target reads zero and writes nothing. It raises illegal_o when the effective virtualization bit is 0 and virtual_o when it is 1.
- R7: Machine-level addresses need priv_i = 11, and otherwise raise illegal_o. Supervisor-level addresses need priv_i of 01 or 11. From user mode (00) they raise virtual_o when virtualized and illegal_o otherwise.
- R8: A direct access to a virtual-supervisor address (bits [9:8] = 10) raises virtual_o when virtualized. Otherwise it needs priv_i of 01 or 11 and raises illegal_o from user mode.
- R9: A trapped access reads zero and changes no select register or target.
- R10: illegal_o and virtual_o are never both set. A privilege fault from R7 or R8 is reported instead of a missing-target fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access present this cycle |
| req_addr_i | input | 12 | Control-register address |
| req_we_i | input | 1 | Access writes |
| req_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Privilege mode: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Virtualization bit |
| rdata_o | output | XLEN | Read data, zero when nothing is read |
| illegal_o | output | 1 | Illegal-instruction trap |
| virtual_o | output | 1 | Virtual-instruction trap |

## Verification
The remap of a supervisor address to the virtual-supervisor set and the missing-target check can act on the same access. The bench provokes this by loading the supervisor select with a value that has a target and the virtual-supervisor select with one that has none. It then reads a supervisor alias with virtualization on. The expected result is a virtual-instruction trap with zero data, where the unremapped path would have returned the supervisor target. It also checks that a privilege fault on that same access suppresses the mapping fault. Random accesses then mix select writes, remapped aliases and user-mode faults against a bench model.

// File: rtl/ind_pkg.sv
package ind_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_S    = 2'b01,
    LVL_VS   = 2'b10,
    LVL_M    = 2'b11
  } lvl_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned ALIAS_W = 3;

  typedef struct packed {
    logic               hit;
    logic               is_sel;
    lvl_e               lvl;
    logic [ALIAS_W-1:0] alias_idx;
  } dec_t;

  function automatic logic [1:0] lvl_slot(lvl_e l);
    case (l)
      LVL_S:   return 2'd1;
      LVL_VS:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ind_addr_decode.sv
module ind_addr_decode
  import ind_pkg::*;
(
  input  logic [11:0] addr_i,
  output dec_t        dec_o
);

  logic [3:0] lo;
  assign lo = addr_i[3:0];

  always_comb begin
    dec_o.hit       = (addr_i[11:10] == 2'b00) && (addr_i[7:4] == 4'h5) &&
                      (addr_i[9:8] != 2'b00) && (lo <= 4'd7) && (lo != 4'd4);
    dec_o.is_sel    = (lo == 4'd0);
    dec_o.lvl       = lvl_e'(addr_i[9:8]);
    if (lo == 4'd0)      dec_o.alias_idx = '0;
    else if (lo < 4'd4)  dec_o.alias_idx = ALIAS_W'(lo - 4'd1);
    else                 dec_o.alias_idx = ALIAS_W'(lo - 4'd2);
  end

endmodule

// File: rtl/ind_select_regs.sv
module ind_select_regs
  import ind_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [1:0]                     slot_i,
  input  logic [XLEN-1:0]                wdata_i,
  output logic [NUM_LVL-1:0][XLEN-1:0]   sel_o
);

  for (genvar s = 0; s < NUM_LVL; s++) begin : g_sel
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && slot_i == 2'(s))      q <= wdata_i;
    end
    assign sel_o[s] = q;
  end

  // R3
  sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sel_o[$past(slot_i)] == $past(wdata_i));

endmodule

// File: rtl/ind_target_file.sv
module ind_target_file #(
  parameter int unsigned              XLEN      = 32,
  parameter int unsigned              NUM_TGT   = 4,
  parameter logic [NUM_TGT*2-1:0]     TGT_LVL   = '0,
  parameter logic [NUM_TGT*XLEN-1:0]  TGT_SEL   = '0,
  parameter logic [NUM_TGT*3-1:0]     TGT_ALIAS = '0,
  parameter logic [NUM_TGT*XLEN-1:0]  TGT_RST   = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      lkp_lvl_i,
  input  logic [XLEN-1:0] lkp_sel_i,
  input  logic [2:0]      lkp_alias_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            hit_o,
  output logic [XLEN-1:0] rdata_o
);

  localparam int unsigned IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic [NUM_TGT-1:0]      match;
  logic [NUM_TGT-1:0]      wr_en;
  logic [NUM_TGT*XLEN-1:0] tgt_flat;
  logic [IDX_W-1:0]        pick;

  always_comb begin
    hit_o = 1'b0;
    pick  = '0;
    for (int g = NUM_TGT - 1; g >= 0; g--) begin
      if (match[g]) begin
        hit_o = 1'b1;
        pick  = IDX_W'(g);
      end
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
    logic [XLEN-1:0] q;
    assign match[g] = (lkp_lvl_i == TGT_LVL[g*2 +: 2]) &&
                      (lkp_alias_i == TGT_ALIAS[g*3 +: 3]) &&
                      (lkp_sel_i == TGT_SEL[g*XLEN +: XLEN]);
    assign wr_en[g] = we_i && hit_o && (pick == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= TGT_RST[g*XLEN +: XLEN];
      else if (wr_en[g]) q <= wdata_i;
    end
    assign tgt_flat[g*XLEN +: XLEN] = q;
  end

  assign rdata_o = hit_o ? tgt_flat[pick*XLEN +: XLEN] : '0;

  // R4
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));

  // R6
  miss_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(tgt_flat));

endmodule

// File: rtl/csr_ind_window.sv
module csr_ind_window
  import ind_pkg::*;
#(
  parameter int unsigned              XLEN      = 32,
  parameter int unsigned              NUM_TGT   = 4,
  parameter logic [NUM_TGT*2-1:0]     TGT_LVL   = {2'b10, 2'b01, 2'b11, 2'b11},
  parameter logic [NUM_TGT*XLEN-1:0]  TGT_SEL   = {32'h20, 32'h20, 32'h10, 32'h10},
  parameter logic [NUM_TGT*3-1:0]     TGT_ALIAS = {3'd1, 3'd1, 3'd5, 3'd0},
  parameter logic [NUM_TGT*XLEN-1:0]  TGT_RST   = {32'h0BAD_F00D, 32'h0000_0000,
                                                   32'h1111_2222, 32'hA5A5_0000}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [11:0]     req_addr_i,
  input  logic            req_we_i,
  input  logic [XLEN-1:0] req_wdata_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            illegal_o,
  output logic            virtual_o
);

  dec_t                         dec;
  logic [NUM_LVL-1:0][XLEN-1:0] sel_vec;
  logic                         eff_v, priv_ge_s, acc;
  logic                         priv_ill, priv_virt, alias_miss;
  lvl_e                         tgt_lvl;
  logic [1:0]                   slot;
  logic [XLEN-1:0]              cur_sel, tgt_rdata;
  logic                         tgt_hit, ok, sel_we, tgt_we;

  ind_addr_decode u_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  assign eff_v     = virt_i && (priv_i != PRIV_M);
  assign priv_ge_s = (priv_i == PRIV_S) || (priv_i == PRIV_M);
  assign acc       = req_valid_i && dec.hit;

  always_comb begin
    priv_ill  = 1'b0;
    priv_virt = 1'b0;
    if (acc) begin
      case (dec.lvl)
        LVL_M: priv_ill = (priv_i != PRIV_M);
        LVL_S: if (!priv_ge_s) begin
                 priv_virt = eff_v;
                 priv_ill  = !eff_v;
               end
        LVL_VS: begin
                 // Remapped supervisor accesses never reach this check
                 priv_virt = eff_v;
                 priv_ill  = !eff_v && !priv_ge_s;
               end
        default: ;
      endcase
    end
  end

  assign tgt_lvl = (dec.lvl == LVL_S && eff_v) ? LVL_VS : dec.lvl;
  assign slot    = lvl_slot(tgt_lvl);
  assign cur_sel = sel_vec[slot];

  ind_select_regs #(.XLEN(XLEN)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_we),
    .slot_i  (slot),
    .wdata_i (req_wdata_i),
    .sel_o   (sel_vec)
  );

  ind_target_file #(
    .XLEN      (XLEN),
    .NUM_TGT   (NUM_TGT),
    .TGT_LVL   (TGT_LVL),
    .TGT_SEL   (TGT_SEL),
    .TGT_ALIAS (TGT_ALIAS),
    .TGT_RST   (TGT_RST)
  ) u_tgt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lkp_lvl_i   (tgt_lvl),
    .lkp_sel_i   (cur_sel),
    .lkp_alias_i (dec.alias_idx),
    .we_i        (tgt_we),
    .wdata_i     (req_wdata_i),
    .hit_o       (tgt_hit),
    .rdata_o     (tgt_rdata)
  );

  assign alias_miss = acc && !dec.is_sel && !tgt_hit && !priv_ill && !priv_virt;
  assign illegal_o  = priv_ill  || (alias_miss && !eff_v);
  assign virtual_o  = priv_virt || (alias_miss && eff_v);
  assign ok         = acc && !illegal_o && !virtual_o;
  assign sel_we     = ok && req_we_i && dec.is_sel;
  assign tgt_we     = ok && req_we_i && !dec.is_sel;
  assign rdata_o    = !ok ? '0 : (dec.is_sel ? cur_sel : tgt_rdata);

  // R10
  trap_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && virtual_o));

  // R9
  trap_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o || virtual_o) |=> $stable(sel_vec));

  // R8
  vs_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dec.hit && dec.lvl == LVL_VS && eff_v) |-> virtual_o);

  // R7
  m_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && dec.hit && dec.lvl == LVL_M && priv_i != PRIV_M) |-> illegal_o);

  // R6
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !dec.is_sel && !tgt_hit) |-> (rdata_o == '0 && (illegal_o || virtual_o)));

  // R2
  outside_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (!illegal_o && !virtual_o && rdata_o == '0));

endmodule

// File: tb/csr_ind_window_tb_top.sv
module csr_ind_window_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [1:0]  priv = 2'b11;
  logic        virt = 1'b0;
  logic [31:0] rdata;
  logic        ill, vio;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_sel [3];
  logic [31:0] m_tgt [4];
  logic [1:0]  t_lvl   [4] = '{2'b11, 2'b11, 2'b01, 2'b10};
  logic [31:0] t_sel   [4] = '{32'h10, 32'h10, 32'h20, 32'h20};
  logic [2:0]  t_alias [4] = '{3'd0, 3'd5, 3'd1, 3'd1};
  logic [31:0] t_rst   [4] = '{32'hA5A5_0000, 32'h1111_2222, 32'h0, 32'h0BAD_F00D};

  always #10 clk = ~clk;

  csr_ind_window dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_addr_i  (addr),
    .req_we_i    (we),
    .req_wdata_i (wdata),
    .priv_i      (priv),
    .virt_i      (virt),
    .rdata_o     (rdata),
    .illegal_o   (ill),
    .virtual_o   (vio)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end

  // kind: 0 nothing, 1 select slot, 2 target index
  task automatic model(input logic v_in, input logic [11:0] a, input logic [1:0] p,
                       input logic v, output logic [31:0] rd, output logic e_ill,
                       output logic e_vi, output int kind, output int idx);
    logic       eff, ge_s, hit;
    logic [3:0] lo;
    logic [1:0] lvl, tl;
    int         slot, ai;
    rd = '0; e_ill = 1'b0; e_vi = 1'b0; kind = 0; idx = 0;
    eff  = v && (p != 2'b11);
    ge_s = (p == 2'b01) || (p == 2'b11);
    lo   = a[3:0];
    hit  = v_in && a[11:10] == 2'b00 && a[7:4] == 4'h5 && a[9:8] != 2'b00 &&
           lo <= 4'd7 && lo != 4'd4;
    if (!hit) return;
    lvl = a[9:8];
    if (lvl == 2'b11 && p != 2'b11) e_ill = 1'b1;
    if (lvl == 2'b01 && !ge_s) begin e_vi = eff; e_ill = !eff; end
    if (lvl == 2'b10) begin
      if (eff) e_vi = 1'b1;
      else if (!ge_s) e_ill = 1'b1;
    end
    if (e_ill || e_vi) return;
    tl   = (lvl == 2'b01 && eff) ? 2'b10 : lvl;
    slot = (tl == 2'b11) ? 0 : (tl == 2'b01) ? 1 : 2;
    if (lo == 4'd0) begin
      kind = 1; idx = slot; rd = m_sel[slot];
      return;
    end
    ai = (lo < 4'd4) ? int'(lo) - 1 : int'(lo) - 2;
    for (int t = 3; t >= 0; t--)
      if (t_lvl[t] == tl && int'(t_alias[t]) == ai && t_sel[t] == m_sel[slot]) begin
        kind = 2; idx = t;
      end
    if (kind == 2) rd = m_tgt[idx];
    else begin e_vi = eff; e_ill = !eff; end
  endtask

  task automatic access(input string tag, input logic [11:0] a, input logic w,
                        input logic [31:0] d, input logic [1:0] p, input logic v,
                        input logic vl = 1'b1);
    logic [31:0] e_rd;
    logic        e_ill, e_vi;
    int          kind, idx;
    @(negedge clk);
    valid = vl; addr = a; we = w; wdata = d; priv = p; virt = v;
    #5;
    model(vl, a, p, v, e_rd, e_ill, e_vi, kind, idx);
    checks++;
    if (rdata !== e_rd || ill !== e_ill || vio !== e_vi) begin
      fails++;
      $display("FAIL %s addr=%h priv=%0d v=%0d: got rd=%h ill=%0b vi=%0b expected rd=%h ill=%0b vi=%0b",
               tag, a, p, v, rdata, ill, vio, e_rd, e_ill, e_vi);
    end
    @(posedge clk);
    #1;
    if (w && kind == 1) m_sel[idx] = d;
    if (w && kind == 2) m_tgt[idx] = d;
    valid = 1'b0; we = 1'b0;
  endtask

  function automatic logic [11:0] pick_addr(int r);
    logic [11:0] lst [18] = '{12'h350, 12'h351, 12'h352, 12'h353, 12'h355, 12'h357,
                              12'h150, 12'h151, 12'h152, 12'h153, 12'h156, 12'h250,
                              12'h252, 12'h255, 12'h354, 12'h154, 12'h358, 12'h050};
    return lst[r % 18];
  endfunction

  function automatic logic [31:0] pick_data(int r);
    case (r % 5)
      0: return 32'h0;
      1: return 32'h10;
      2: return 32'h20;
      3: return 32'h30;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) m_sel[i] = '0;
    for (int i = 0; i < 4; i++) m_tgt[i] = t_rst[i];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    access("R1 m select reset", 12'h350, 0, 0, 2'b11, 0);
    access("R1 s select reset", 12'h150, 0, 0, 2'b01, 0);
    access("R1 vs select reset", 12'h250, 0, 0, 2'b01, 0);
    // R6 select zero has no target
    access("R6 unmapped alias illegal", 12'h351, 0, 0, 2'b11, 0);
    // R3 / R4 / R1
    access("R3 m select write", 12'h350, 1, 32'h10, 2'b11, 0);
    access("R3 m select read", 12'h350, 0, 0, 2'b11, 0);
    access("R1 R4 target reset alias0", 12'h351, 0, 0, 2'b11, 0);
    access("R2 R4 alias5 at nibble7", 12'h357, 0, 0, 2'b11, 0);
    access("R2 hole 0x354", 12'h354, 1, 32'hFFFF_FFFF, 2'b11, 0);
    access("R2 invalid cycle", 12'h351, 1, 32'h1, 2'b11, 0, 1'b0);
    access("R4 target write", 12'h351, 1, 32'hDEAD_BEEF, 2'b11, 0);
    access("R4 target readback", 12'h351, 0, 0, 2'b11, 0);
    access("R6 unmapped write dropped", 12'h353, 1, 32'h5555, 2'b11, 0);
    access("R6 neighbour unchanged", 12'h351, 0, 0, 2'b11, 0);
    // supervisor
    access("R3 s select write", 12'h150, 1, 32'h20, 2'b01, 0);
    access("R4 s target read", 12'h152, 0, 0, 2'b01, 0);
    access("R4 s target write", 12'h152, 1, 32'h1234, 2'b01, 0);
    access("R4 s target readback", 12'h152, 0, 0, 2'b01, 0);
    // R5 remap, combined with R6
    access("R5 remapped select read", 12'h150, 0, 0, 2'b01, 1);
    access("R5 R6 remap then miss virtual", 12'h152, 0, 0, 2'b01, 1);
    access("R10 user fault beats miss", 12'h152, 0, 0, 2'b00, 1);
    access("R5 remapped select write", 12'h150, 1, 32'h20, 2'b01, 1);
    access("R5 remapped alias hits vs", 12'h152, 0, 0, 2'b01, 1);
    access("R5 vs select direct", 12'h250, 0, 0, 2'b01, 0);
    access("R5 m ignores virt", 12'h150, 0, 0, 2'b11, 1);
    access("R5 s select kept", 12'h150, 0, 0, 2'b01, 0);
    // R8
    access("R8 direct vs virtualized", 12'h252, 0, 0, 2'b01, 1);
    access("R8 direct vs from user", 12'h252, 0, 0, 2'b00, 0);
    access("R8 direct vs from s", 12'h252, 0, 0, 2'b01, 0);
    // R7 / R9
    access("R7 s to m illegal", 12'h350, 0, 0, 2'b01, 0);
    access("R7 vs to m illegal", 12'h351, 0, 0, 2'b01, 1);
    access("R7 vu to s virtual", 12'h150, 0, 0, 2'b00, 1);
    access("R7 u to s illegal", 12'h151, 0, 0, 2'b00, 0);
    access("R9 trapped write", 12'h350, 1, 32'hFFFF, 2'b01, 0);
    access("R9 select unchanged", 12'h350, 0, 0, 2'b11, 0);
    access("R9 trapped vs write", 12'h250, 1, 32'h77, 2'b01, 1);
    access("R9 vs select unchanged", 12'h250, 0, 0, 2'b01, 0);

    // R10 random mix
    for (int n = 0; n < 600; n++) begin
      int          r1, r2;
      logic [1:0]  p;
      r1 = int'($urandom % 1000);
      r2 = int'($urandom % 1000);
      case (r2 % 3)
        0: p = 2'b00;
        1: p = 2'b01;
        default: p = 2'b11;
      endcase
      access("R10 random", pick_addr(r1), r1[0] ^ r2[1], pick_data(r2), p, r2[4]);
    end

    finish_run();
  end

endmodule